// File: doc/BRIEF.md
# Console UART

A small serial console peripheral that sits on a 64-bit register bus. Software places bytes into a 16-entry transmit queue by storing to one register, and takes received bytes from a 16-entry receive queue by loading from another. A status register reports whether each queue is empty or full. An interrupt line can be enabled separately for "received data waiting" and "transmit queue drained". The serial side sends and receives 8 data bits with no parity and one stop bit, LSB first. Both directions share one programmable baud tick that is oversampled 16 times per bit.

The divisor register holds the number of clocks per baud tick minus one. For a clock `f` and a bit rate `b`, software writes `f / (16*b) - 1`. The receiver qualifies a start bit at the middle of the bit and samples every later bit at its centre. The bus takes one request per cycle and returns the acknowledge, with any read data, exactly one cycle later.

Top module: `console_uart`

## Requirements
- R1: After reset, the status register reads 0x3, the divisor and interrupt-enable registers read 0, `irq` is low, and `ser_tx` idles high.
- R2: Every cycle with `bus_valid` high is followed, in the next cycle, by `bus_ack` high; `bus_ack` is low after a cycle with no request. Read data is valid in the acknowledge cycle.
- R3: A store to offset 0x00 queues bits 7:0. The byte goes out as a frame: one low start bit, eight data bits LSB first, one high stop bit.
- R4: The transmit queue holds 16 bytes, counting none already in the shifter. Status bit 3 is set while it is full. A store to offset 0x00 while it is full is discarded.
- R5: A correctly framed byte on `ser_rx` is queued. A load from offset 0x08 returns it in bits 7:0, with zero above, and removes it from the queue in arrival order.
- R6: A low pulse on `ser_rx` that has ended before the middle of a bit period is not taken as a start bit, and it queues nothing.
- R7: The receive queue holds 16 bytes. Status bit 2 is set while it is full. A byte that completes while it is full is discarded.
- R8: Status at offset 0x10 reads: bit 0 receive empty, bit 1 transmit empty, bit 2 receive full, bit 3 transmit full. All other bits read 0.
- R9: The divisor at offset 0x18 reads back as written in its low 16 bits. Every serial bit lasts exactly 16*(divisor+1) clocks.
- R10: `irq` is high while (interrupt-enable bit 0 is set and the receive queue holds data) or (bit 1 is set and the transmit queue is empty). The register is at offset 0x20.
- R11: A load from offset 0x08 while the receive queue is empty returns 0 and changes no status.
- R12: Loads from offsets that are unmapped or not doubleword-aligned return 0. Stores to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one request per cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 64 | Store data |
| bus_rdata | output | 64 | Load data, valid with `bus_ack` |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| irq | output | 1 | Interrupt request, level |
| ser_tx | output | 1 | Serial transmit line, idle high |
| ser_rx | input | 1 | Serial receive line, asynchronous |

## Verification
The properties assume that `bus_valid` and `bus_write` are never unknown once reset has been released. The bench drives every bus signal to a known value from time zero. The checks on frame timing also assume that the divisor does not change while a frame is in progress on either line. The bench therefore changes the divisor only after both serial lines have been idle for longer than a frame. The receiver assumes the far end sends frames at the rate the divisor sets, so the bench generates each serial bit for exactly 16*(divisor+1) clocks.

// File: rtl/console_uart_pkg.sv
`timescale 1ns/1ps
package console_uart_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_W      = 64;
    localparam int FRAME_BITS = BYTE_W + 2;

    // register selectors, taken from address bits 5:3
    localparam logic [2:0] SEL_TXD  = 3'd0;
    localparam logic [2:0] SEL_RXD  = 3'd1;
    localparam logic [2:0] SEL_STAT = 3'd2;
    localparam logic [2:0] SEL_DIV  = 3'd3;
    localparam logic [2:0] SEL_IEN  = 3'd4;

    // status layout: the last member is bit 0
    typedef struct packed {
        logic tx_full;
        logic rx_full;
        logic tx_empty;
        logic rx_empty;
    } stat_t;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
    } ien_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    // the frame is shifted out from bit 0: start, data LSB first, stop
    function automatic logic [FRAME_BITS-1:0] make_frame(input logic [BYTE_W-1:0] d);
        return {1'b1, d, 1'b0};
    endfunction

endpackage

// File: rtl/cu_baud.sv
`timescale 1ns/1ps
module cu_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // the >= keeps the counter bounded when the divisor is lowered
    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/cu_fifo.sv
`timescale 1ns/1ps
module cu_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    // DEPTH is a power of two; the extra pointer bit tells full from empty
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr;
    logic [AW:0]      rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign head  = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) begin
                mem[wr_ptr[AW-1:0]] <= push_data;
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop && !empty)
                rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/cu_tx.sv
`timescale 1ns/1ps
module cu_tx
    import console_uart_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              have_data,
    input  logic [BYTE_W-1:0] data,
    output logic              pop,
    output logic              busy,
    output logic              line
);
    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam int BN_W = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [PH_W-1:0]       phase;
    logic [BN_W-1:0]       bitn;

    // a frame starts only on a tick, so every bit is a whole number of ticks
    assign pop  = !busy && tick && have_data;
    assign line = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '1;
            phase <= '0;
            bitn  <= '0;
        end else if (!busy) begin
            if (pop) begin
                shreg <= make_frame(data);
                busy  <= 1'b1;
                phase <= '0;
                bitn  <= '0;
            end
        end else if (tick) begin
            if (phase == PH_W'(OVERSAMPLE - 1)) begin
                phase <= '0;
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                if (bitn == BN_W'(FRAME_BITS - 1))
                    busy <= 1'b0;
                else
                    bitn <= bitn + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cu_rx.sv
`timescale 1ns/1ps
module cu_rx
    import console_uart_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line_async,
    output logic              valid,
    output logic [BYTE_W-1:0] data
);
    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVERSAMPLE / 2 - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

    logic [1:0]        sync;
    logic              rx_s;
    rx_state_e         state;
    logic [PH_W-1:0]   phase;
    logic [BC_W-1:0]   bitn;
    logic [BYTE_W-1:0] shreg;

    assign rx_s = sync[1];
    assign data = shreg;

    always_ff @(posedge clk) begin
        if (rst)
            sync <= 2'b11;
        else
            sync <= {sync[0], line_async};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            phase <= '0;
            bitn  <= '0;
            shreg <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state <= RX_START;
                            phase <= '0;
                        end
                    end
                    RX_START: begin
                        if (phase == PH_MID) begin
                            phase <= '0;
                            bitn  <= '0;
                            state <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (phase == PH_LAST) begin
                            phase <= '0;
                            shreg <= {rx_s, shreg[BYTE_W-1:1]};
                            if (bitn == BC_W'(BYTE_W - 1))
                                state <= RX_STOP;
                            else
                                bitn <= bitn + 1'b1;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (phase == PH_LAST) begin
                            phase <= '0;
                            state <= RX_IDLE;
                            valid <= rx_s;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/console_uart.sv
`timescale 1ns/1ps
module console_uart
    import console_uart_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DIV_W      = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_ack,
    output logic              irq,
    output logic              ser_tx,
    input  logic              ser_rx
);
    localparam int SEL_LO = 3;
    localparam int SEL_HI = 5;

    logic [2:0]        sel;
    logic              hit;
    logic              wr_req;
    logic              rd_req;
    logic              tx_push;
    logic              tx_pop;
    logic              tx_busy;
    logic              tx_empty;
    logic              tx_full;
    logic [BYTE_W-1:0] tx_head;
    logic              rx_pop;
    logic              rx_push;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_empty;
    logic              rx_full;
    logic [BYTE_W-1:0] rx_head;
    logic              tick;
    logic [DIV_W-1:0]  div_q;
    ien_t              ien_q;
    stat_t             stat;
    logic [REG_W-1:0]  rd_mux;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[REG_W-1:DIV_W];

    // decode: doubleword aligned, upper bits zero
    assign sel    = bus_addr[SEL_HI:SEL_LO];
    assign hit    = (bus_addr[ADDR_W-1:SEL_HI+1] == '0) && (bus_addr[SEL_LO-1:0] == '0);
    assign wr_req = bus_valid && bus_write && hit;
    assign rd_req = bus_valid && !bus_write && hit;

    assign tx_push = wr_req && (sel == SEL_TXD);
    assign rx_pop  = rd_req && (sel == SEL_RXD) && !rx_empty;

    assign stat = '{tx_full: tx_full, rx_full: rx_full, tx_empty: tx_empty, rx_empty: rx_empty};

    always_comb begin
        rd_mux = '0;
        if (rd_req) begin
            unique case (sel)
                SEL_RXD:  rd_mux = rx_empty ? '0 : REG_W'(rx_head);
                SEL_STAT: rd_mux = REG_W'(stat);
                SEL_DIV:  rd_mux = REG_W'(div_q);
                SEL_IEN:  rd_mux = REG_W'(ien_q);
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            div_q     <= '0;
            ien_q     <= '0;
        end else begin
            bus_ack   <= bus_valid;
            bus_rdata <= rd_mux;
            if (wr_req && sel == SEL_DIV)
                div_q <= bus_wdata[DIV_W-1:0];
            if (wr_req && sel == SEL_IEN)
                ien_q <= bus_wdata[1:0];
        end
    end

    assign irq = (ien_q.rx_en && !rx_empty) || (ien_q.tx_en && tx_empty);

    cu_baud #(.DIV_W(DIV_W)) u_baud (
        .clk (clk),
        .rst (rst),
        .div (div_q),
        .tick(tick)
    );

    cu_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk      (clk),
        .rst      (rst),
        .push     (tx_push),
        .push_data(bus_wdata[BYTE_W-1:0]),
        .pop      (tx_pop),
        .head     (tx_head),
        .empty    (tx_empty),
        .full     (tx_full)
    );

    cu_tx #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .have_data(!tx_empty),
        .data     (tx_head),
        .pop      (tx_pop),
        .busy     (tx_busy),
        .line     (ser_tx)
    );

    cu_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .line_async(ser_rx),
        .valid     (rx_push),
        .data      (rx_byte)
    );

    cu_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .push     (rx_push),
        .push_data(rx_byte),
        .pop      (rx_pop),
        .head     (rx_head),
        .empty    (rx_empty),
        .full     (rx_full)
    );
endmodule

// File: rtl/console_uart_chk.sv
`timescale 1ns/1ps
module console_uart_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_valid,
    input logic       bus_ack,
    input logic       tx_push,
    input logic       tx_pop,
    input logic       tx_busy,
    input logic       tx_empty,
    input logic       tx_full,
    input logic       rx_empty,
    input logic       rx_full,
    input logic [1:0] ien,
    input logic       irq,
    input logic       ser_tx
);
    p_ack_follows_r2: assert property (@(posedge clk) disable iff (rst)
        bus_valid |=> bus_ack);

    p_no_stray_ack_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_valid |=> !bus_ack);

    p_line_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> ser_tx);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full && !tx_pop) |=> tx_full);

    p_flags_disjoint_r8: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

    p_rx_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (ien[0] && !rx_empty) |-> irq);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (ien == 2'b00) |-> !irq);
endmodule

bind console_uart console_uart_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_valid(bus_valid),
    .bus_ack  (bus_ack),
    .tx_push  (tx_push),
    .tx_pop   (tx_pop),
    .tx_busy  (tx_busy),
    .tx_empty (tx_empty),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .rx_full  (rx_full),
    .ien      (ien_q),
    .irq      (irq),
    .ser_tx   (ser_tx)
);

// File: tb/console_uart_bench.sv
`timescale 1ns/1ps
module console_uart_bench;

    localparam logic [7:0] A_TXD  = 8'h00;
    localparam logic [7:0] A_RXD  = 8'h08;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_DIV  = 8'h18;
    localparam logic [7:0] A_IEN  = 8'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_ack;
    logic        irq;
    logic        ser_tx;
    logic        ser_rx = 1'b1;

    int checks = 0;
    int errors = 0;
    int mon_period = 16;
    int mon_cnt = 0;
    logic [7:0] mon_log [64];

    always #2.5 clk = ~clk;

    console_uart u_console_uart (
        .clk      (clk),
        .rst      (rst),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .bus_ack  (bus_ack),
        .irq      (irq),
        .ser_tx   (ser_tx),
        .ser_rx   (ser_rx)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        if (bus_ack !== 1'b1) check("R2 write ack", {63'd0, bus_ack}, 64'd1);
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        if (bus_ack !== 1'b1) check("R2 read ack", {63'd0, bus_ack}, 64'd1);
        d = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int period);
        @(negedge clk);
        ser_rx = 1'b0;
        wait_clk(period);
        for (int i = 0; i < 8; i++) begin
            ser_rx = b[i];
            wait_clk(period);
        end
        ser_rx = 1'b1;
        wait_clk(period + period / 2);
    endtask

    // serial monitor on ser_tx
    initial begin
        logic [7:0] b;
        logic ok;
        forever begin
            @(negedge clk);
            if (ser_tx === 1'b0) begin
                wait_clk(mon_period / 2);
                ok = (ser_tx === 1'b0);
                for (int i = 0; i < 8; i++) begin
                    wait_clk(mon_period);
                    b[i] = ser_tx;
                end
                wait_clk(mon_period);
                ok = ok && (ser_tx === 1'b1);
                if (!ok) check("R3 frame shape", 64'd0, 64'd1);
                if (mon_cnt < 64) mon_log[mon_cnt] = b;
                mon_cnt++;
            end
        end
    end

    task automatic test_reset;
        logic [63:0] d;
        check("R1 irq after reset", {63'd0, irq}, 64'd0);
        check("R1 ser_tx idle", {63'd0, ser_tx}, 64'd1);
        bus_rd(A_STAT, d); check("R1 R8 status after reset", d, 64'h3);
        bus_rd(A_DIV, d);  check("R1 divisor after reset", d, 64'h0);
        bus_rd(A_IEN, d);  check("R1 enables after reset", d, 64'h0);
    endtask

    task automatic test_regs;
        logic [63:0] d;
        bus_wr(A_DIV, 64'hFFFF_0000_0000_1234);
        bus_rd(A_DIV, d); check("R9 divisor readback", d, 64'h1234);
        bus_wr(A_IEN, 64'h3);
        bus_rd(A_IEN, d); check("R10 enable readback", d, 64'h3);
        bus_wr(8'h28, 64'hFF);
        bus_wr(8'h1C, 64'h55);
        bus_wr(8'h58, 64'h77);
        bus_rd(8'h28, d); check("R12 unmapped read", d, 64'h0);
        bus_rd(8'h1C, d); check("R12 unaligned read", d, 64'h0);
        bus_rd(8'h58, d); check("R12 alias read", d, 64'h0);
        bus_rd(A_DIV, d); check("R12 divisor untouched", d, 64'h1234);
        bus_wr(A_IEN, 64'h0);
        bus_wr(A_DIV, 64'h0);
        bus_rd(A_STAT, d); check("R12 no byte queued", d, 64'h3);
    endtask

    task automatic test_tx_basic;
        logic [63:0] d;
        mon_period = 16; mon_cnt = 0;
        bus_wr(A_TXD, 64'hFFFF_FFFF_FFFF_FFA5);
        bus_wr(A_TXD, 64'h3C);
        wait_clk(400);
        check("R3 byte count", 64'(mon_cnt), 64'd2);
        check("R3 first byte", {56'd0, mon_log[0]}, 64'hA5);
        check("R3 second byte", {56'd0, mon_log[1]}, 64'h3C);
        bus_rd(A_STAT, d); check("R8 tx drained", d, 64'h3);
    endtask

    task automatic test_tx_timing;
        int lowcnt = 0;
        int guard = 0;
        mon_period = 48; mon_cnt = 0;
        bus_wr(A_DIV, 64'd2);
        bus_wr(A_TXD, 64'h00);
        while (ser_tx !== 1'b0 && guard < 200) begin
            @(negedge clk); guard++;
        end
        while (ser_tx === 1'b0 && lowcnt < 1000) begin
            lowcnt++; @(negedge clk);
        end
        check("R9 R3 nine low bits at divisor 2", 64'(lowcnt), 64'd432);
        wait_clk(150);
        check("R9 byte at divisor 2", {56'd0, mon_log[0]}, 64'h00);
        bus_wr(A_DIV, 64'd0);
        mon_period = 16;
        wait_clk(20);
    endtask

    task automatic test_tx_full;
        logic [63:0] d;
        logic ok = 1'b1;
        mon_period = 16; mon_cnt = 0;
        for (int i = 0; i < 18; i++) bus_wr(A_TXD, 64'(8'h10 + i));
        bus_rd(A_STAT, d); check("R4 R8 tx full flag", d, 64'h9);
        wait_clk(17 * 160 + 300);
        check("R4 frames sent, extra store dropped", 64'(mon_cnt), 64'd17);
        for (int i = 0; i < 17; i++)
            if (mon_log[i] !== 8'(8'h10 + i)) ok = 1'b0;
        check("R4 order of queued bytes", {63'd0, ok}, 64'd1);
    endtask

    task automatic test_rx_basic;
        logic [63:0] d;
        send_byte(8'h5A, 16);
        send_byte(8'hC3, 16);
        bus_rd(A_STAT, d); check("R5 R8 rx holds data", d, 64'h2);
        bus_rd(A_RXD, d);  check("R5 first received", d, 64'h5A);
        bus_rd(A_RXD, d);  check("R5 second received", d, 64'hC3);
        bus_rd(A_STAT, d); check("R5 rx empty after pops", d, 64'h3);
    endtask

    task automatic test_rx_glitch;
        logic [63:0] d;
        @(negedge clk); ser_rx = 1'b0;
        wait_clk(4);
        ser_rx = 1'b1;
        wait_clk(250);
        bus_rd(A_STAT, d); check("R6 glitch queued nothing", d, 64'h3);
        bus_rd(A_RXD, d);  check("R11 empty read returns zero", d, 64'h0);
        bus_rd(A_STAT, d); check("R11 empty read left status", d, 64'h3);
        send_byte(8'h81, 16);
        bus_rd(A_RXD, d);  check("R6 receiver recovers", d, 64'h81);
    endtask

    task automatic test_rx_full;
        logic [63:0] d;
        logic ok = 1'b1;
        for (int i = 0; i < 17; i++) send_byte(8'(8'h40 + i), 16);
        bus_rd(A_STAT, d); check("R7 R8 rx full flag", d, 64'h6);
        for (int i = 0; i < 16; i++) begin
            bus_rd(A_RXD, d);
            if (d !== 64'(8'h40 + i)) ok = 1'b0;
        end
        check("R7 sixteen bytes in order", {63'd0, ok}, 64'd1);
        bus_rd(A_STAT, d); check("R7 seventeenth byte dropped", d, 64'h3);
    endtask

    task automatic test_irq;
        logic [63:0] d;
        bus_wr(A_IEN, 64'h1); wait_clk(1);
        check("R10 rx enable, queue empty", {63'd0, irq}, 64'd0);
        bus_wr(A_IEN, 64'h2); wait_clk(1);
        check("R10 tx enable, tx empty", {63'd0, irq}, 64'd1);
        bus_wr(A_IEN, 64'h0); wait_clk(1);
        check("R10 all disabled", {63'd0, irq}, 64'd0);
        bus_wr(A_IEN, 64'h1);
        send_byte(8'h99, 16);
        check("R10 rx data raises irq", {63'd0, irq}, 64'd1);
        bus_rd(A_RXD, d);
        check("R10 irq drops after pop", {63'd0, irq}, 64'd0);
        bus_wr(A_IEN, 64'h0);
    endtask

    task automatic test_rx_div;
        logic [63:0] d;
        bus_wr(A_DIV, 64'd3);
        wait_clk(10);
        send_byte(8'h6E, 64);
        bus_rd(A_RXD, d); check("R5 R9 receive at divisor 3", d, 64'h6E);
        bus_wr(A_DIV, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        test_reset();
        test_regs();
        test_tx_basic();
        test_tx_timing();
        test_tx_full();
        test_rx_basic();
        test_rx_glitch();
        test_rx_full();
        test_irq();
        test_rx_div();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule